// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block is the clocked control core for one synchronous buck power stage. It takes a single pulse-width-modulated command and produces two gate-enable outputs, one for the high-side switch and one for the low-side switch. It also honours four protection inputs:
- an overvoltage clamp request;
- an undervoltage-lockout flag;
- an active-low shutdown;
- a low-side enable.

A digitized flag from a switch-node comparator reports that the switch node has fallen to ground.

Turn-on of the low-side switch is gated twice. It must wait until the high-side output is seen off. It must also wait until the switch node is reported low. A cycle counter, restarted on every falling command edge, forces the low-side turn-on if that report never arrives. If the high-side switch has failed short, this forced turn-on creates a deliberate short across the input rail, which blows the upstream fuse and protects the load.

The high-side turn-on waits one clock after the low-side output is seen off. Outside a clamp event, the two outputs are never high together. An overvoltage clamp request wins over every other input. All inputs pass through two-flop synchronizers, and both outputs come from registers.

Top module: `gate_sequencer`

## Requirements
- R1: While the synchronized clamp request is high, hiGate is 0 and loGate is 1, regardless of uvloFlag, shutdownN, lowSideEn and pwmIn.
- R2: While the clamp request is low and uvloFlag is high, both hiGate and loGate are 0.
- R3: While the clamp request and uvloFlag are low and shutdownN is 0, both outputs are 0.
- R4: In normal operation (clamp low, uvloFlag low, shutdownN 1), a steady pwmIn of 1 settles to hiGate 1 and loGate 0.
- R5: In normal operation with lowSideEn 1, a steady pwmIn of 0 gives hiGate 0, and loGate then rises once the synchronized swNodeLow is 1.
- R6: In normal operation with lowSideEn 0, loGate stays 0; hiGate still follows pwmIn.
- R7: hiGate and loGate are never 1 together. hiGate rises only if loGate was 0 in the previous cycle. Outside a clamp event, loGate rises only if hiGate was 0 in the previous cycle.
- R8: Each falling pwmIn edge restarts a count of TIMEOUT_CYC cycles. With swNodeLow held 0, loGate rises at the (TIMEOUT_CYC+4)-th clock edge after the edge that first samples the falling pwmIn (numbering that edge 0). A rising pwmIn before expiry clears the count.
- R9: With the default two-stage synchronizers, edges are numbered from 0 at the edge that first samples the input change:
  - A protection input changes the outputs at edge 2.
  - A falling pwmIn drops hiGate at edge 3. If swNodeLow is already 1, loGate rises at edge 5.
  - A rising pwmIn drops loGate at edge 3 and raises hiGate at edge 5.
  - Leaving a clamp with pwmIn 1 drops loGate at edge 2 and raises hiGate at edge 4.
  - Leaving shutdown with pwmIn 1 raises hiGate at edge 4.
- R10: While rst_n is 0, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwmIn | input | 1 | PWM command, 1 requests high-side conduction |
| shutdownN | input | 1 | Active-low shutdown, 1 lets the stage run |
| uvloFlag | input | 1 | Undervoltage lockout, 1 holds both switches off |
| lowSideEn | input | 1 | Low-side enable, 0 keeps the low-side switch off |
| ovClamp | input | 1 | Overvoltage clamp request, 1 forces the low side on |
| swNodeLow | input | 1 | Comparator flag, 1 when the switch node is near ground |
| hiGate | output | 1 | High-side gate enable (registered) |
| loGate | output | 1 | Low-side gate enable (registered) |

## Verification
A sweep over all 32 combinations of the clamp, lockout, shutdown, low-side-enable and PWM inputs, with the switch-node flag held at 1, checks the settled outputs against the priority rules. This separates the clamp, lockout and shutdown precedence from normal PWM following.

Single PWM edges are then measured edge by edge under three conditions:
- with the switch-node flag already present;
- with the flag arriving a few cycles late;
- with the flag stuck at 0.

These three cases tell the comparator-gated path apart from the timeout-forced path. An aborted falling edge followed by a second one shows that the count restarts.

Clamp entry and exit, and shutdown exit, are timed as well. A continuous monitor watches for overlap of the two outputs and for a turn-on that is not preceded by the other output being off.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

  typedef enum logic [2:0] {
    PH_STOP,
    PH_HION,
    PH_LOWAIT,
    PH_LOON,
    PH_DEAD
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic hiOn;
    logic loOn;
    logic cntRun;
  } strobe_t;

  // synchronized inputs and datapath state seen by control
  typedef struct packed {
    logic inS;
    logic sdnS;
    logic uvloS;
    logic lowEnS;
    logic clampS;
    logic swLowS;
    logic hiQ;
    logic loQ;
    logic expired;
  } status_t;

endpackage

// File: rtl/gdrv_datapath.sv
module gdrv_datapath
  import gdrv_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pwmIn,
  input  logic    shutdownN,
  input  logic    uvloFlag,
  input  logic    lowSideEn,
  input  logic    ovClamp,
  input  logic    swNodeLow,
  input  strobe_t stb,
  output status_t status
);

  localparam int NUM_IN = 6;
  localparam int CW     = $clog2(TIMEOUT_CYC + 1);

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncOut;
  logic [CW-1:0]     cnt;
  logic              expired;
  logic              hiQ;
  logic              loQ;

  assign rawIn = {swNodeLow, ovClamp, lowSideEn, uvloFlag, shutdownN, pwmIn};

  // one synchronizer chain per input
  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[SYNC_STAGES-2:0], rawIn[gi]};
    end
    assign syncOut[gi] = chain[SYNC_STAGES-1];
  end

  // low-side timeout counter, held at zero outside the wait phase
  assign expired = (cnt == CW'(TIMEOUT_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!stb.cntRun) cnt <= '0;
    else if (!expired)    cnt <= cnt + CW'(1);
  end

  // registered gate outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hiQ <= 1'b0;
      loQ <= 1'b0;
    end else begin
      hiQ <= stb.hiOn;
      loQ <= stb.loOn;
    end
  end

  assign status.inS     = syncOut[0];
  assign status.sdnS    = syncOut[1];
  assign status.uvloS   = syncOut[2];
  assign status.lowEnS  = syncOut[3];
  assign status.clampS  = syncOut[4];
  assign status.swLowS  = syncOut[5];
  assign status.hiQ     = hiQ;
  assign status.loQ     = loQ;
  assign status.expired = expired;

endmodule

// File: rtl/gdrv_control.sv
module gdrv_control
  import gdrv_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  status_t status,
  output strobe_t stb
);

  phase_t phase;
  phase_t nextPhase;
  logic   clampOn;
  logic   holdOff;

  assign clampOn = status.clampS;
  assign holdOff = status.uvloS || !status.sdnS;

  always_comb begin
    nextPhase = phase;
    case (phase)
      PH_STOP:   nextPhase = status.inS ? PH_DEAD : PH_LOWAIT;
      PH_HION:   if (!status.inS) nextPhase = PH_LOWAIT;
      PH_LOWAIT: begin
        if (status.inS) nextPhase = PH_DEAD;
        else if (!status.hiQ && (status.swLowS || status.expired)) nextPhase = PH_LOON;
      end
      PH_LOON:   if (status.inS) nextPhase = PH_DEAD;
      PH_DEAD: begin
        if (!status.inS) nextPhase = PH_LOWAIT;
        else if (!status.loQ) nextPhase = PH_HION;
      end
      default:   nextPhase = PH_STOP;
    endcase
    if (clampOn || holdOff) nextPhase = PH_STOP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_STOP;
    else        phase <= nextPhase;
  end

  // priority: clamp, then lockout/shutdown, then the phase machine
  always_comb begin
    if (clampOn) begin
      stb.hiOn   = 1'b0;
      stb.loOn   = 1'b1;
      stb.cntRun = 1'b0;
    end else if (holdOff) begin
      stb.hiOn   = 1'b0;
      stb.loOn   = 1'b0;
      stb.cntRun = 1'b0;
    end else begin
      stb.hiOn   = (phase == PH_HION);
      stb.loOn   = (phase == PH_LOON) && status.lowEnS;
      stb.cntRun = (phase == PH_LOWAIT);
    end
  end

endmodule

// File: rtl/gate_sequencer.sv
module gate_sequencer
  import gdrv_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwmIn,
  input  logic shutdownN,
  input  logic uvloFlag,
  input  logic lowSideEn,
  input  logic ovClamp,
  input  logic swNodeLow,
  output logic hiGate,
  output logic loGate
);

  strobe_t ctlStrobe;
  status_t dpStatus;

  gdrv_datapath #(
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwmIn    (pwmIn),
    .shutdownN(shutdownN),
    .uvloFlag (uvloFlag),
    .lowSideEn(lowSideEn),
    .ovClamp  (ovClamp),
    .swNodeLow(swNodeLow),
    .stb      (ctlStrobe),
    .status   (dpStatus)
  );

  gdrv_control u_control (
    .clk   (clk),
    .rst_n (rst_n),
    .status(dpStatus),
    .stb   (ctlStrobe)
  );

  assign hiGate = dpStatus.hiQ;
  assign loGate = dpStatus.loQ;

endmodule

// File: rtl/gate_sequencer_chk.sv
module gate_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic hiGate,
  input logic loGate,
  input logic clampS,
  input logic uvloS,
  input logic sdnS,
  input logic lowEnS
);

  // R1
  clamp_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clampS |=> (loGate && !hiGate));

  // R2
  uvlo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clampS && uvloS) |=> (!hiGate && !loGate));

  // R3
  shutdown_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clampS && !sdnS) |=> (!hiGate && !loGate));

  // R6
  low_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clampS && !lowEnS) |=> !loGate);

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hiGate && loGate));

  // R7
  hi_after_lo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hiGate) |-> !$past(loGate));

  // R7
  lo_after_hi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(loGate) && !$past(clampS)) |-> !$past(hiGate));

endmodule

bind gate_sequencer gate_sequencer_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .hiGate(hiGate),
  .loGate(loGate),
  .clampS(dpStatus.clampS),
  .uvloS (dpStatus.uvloS),
  .sdnS  (dpStatus.sdnS),
  .lowEnS(dpStatus.lowEnS)
);

// File: tb/gate_sequencer_bench.sv
module gate_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TO_CYC     = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwmIn = 1'b0;
  logic shutdownN = 1'b1;
  logic uvloFlag = 1'b0;
  logic lowSideEn = 1'b1;
  logic ovClamp = 1'b0;
  logic swNodeLow = 1'b1;
  logic hiGate;
  logic loGate;

  int checks = 0;
  int errors = 0;
  int cycleCnt = 0;
  int overlapErr = 0;
  int orderErr = 0;
  logic prevHi = 1'b0;
  logic prevLo = 1'b0;
  logic monitorOn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_sequencer #(.TIMEOUT_CYC(TO_CYC)) u_gate_sequencer (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwmIn    (pwmIn),
    .shutdownN(shutdownN),
    .uvloFlag (uvloFlag),
    .lowSideEn(lowSideEn),
    .ovClamp  (ovClamp),
    .swNodeLow(swNodeLow),
    .hiGate   (hiGate),
    .loGate   (loGate)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called just after a negedge input change; edge 1 = first sampling edge
  task automatic measure(input logic wantHi, input logic wantLo,
                         output int kHi, output int kLo);
    kHi = -1;
    kLo = -1;
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk);
      #1;
      if (kHi < 0 && hiGate == wantHi) kHi = k;
      if (kLo < 0 && loGate == wantLo) kLo = k;
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R7 continuous monitor
  always @(negedge clk) begin
    if (monitorOn) begin
      if (hiGate && loGate) overlapErr++;
      if (hiGate && !prevHi && prevLo) orderErr++;
      if (loGate && !prevLo && prevHi && !ovClamp) orderErr++;
    end
    prevHi <= hiGate;
    prevLo <= loGate;
  end

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 50000) begin
      errors++;
      $display("FAIL watchdog expired (all requirements)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int kHi;
    int kLo;
    // R10 reset state
    pwmIn = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 hiGate in reset", int'(hiGate), 0);
    chk("R10 loGate in reset", int'(loGate), 0);
    rst_n = 1'b1;
    monitorOn = 1'b1;

    // R1..R6 priority sweep
    for (int v = 0; v < 32; v++) begin
      logic cl, uv, sd, le, pin, expHi, expLo;
      cl = v[4]; uv = v[3]; sd = v[2]; le = v[1]; pin = v[0];
      ovClamp = cl; uvloFlag = uv; shutdownN = sd; lowSideEn = le; pwmIn = pin;
      swNodeLow = 1'b1;
      settle(30);
      expHi = !cl && !uv && sd && pin;
      expLo = cl || (!uv && sd && !pin && le);
      chk($sformatf("R1/R2/R3/R4/R5/R6 sweep %0d hiGate", v), int'(hiGate), int'(expHi));
      chk($sformatf("R1/R2/R3/R4/R5/R6 sweep %0d loGate", v), int'(loGate), int'(expLo));
    end

    // normal settings, high side on
    ovClamp = 0; uvloFlag = 0; shutdownN = 1; lowSideEn = 1; swNodeLow = 1;
    pwmIn = 1;
    settle(20);

    // R5 R9 falling edge with switch node already low
    pwmIn = 0;
    measure(1'b0, 1'b1, kHi, kLo);
    chk("R9 hi off after fall", kHi, 4);
    chk("R5 lo on with flag present", kLo, 6);

    // R7 R9 rising edge
    @(negedge clk);
    pwmIn = 1;
    measure(1'b1, 1'b0, kHi, kLo);
    chk("R9 lo off after rise", kLo, 4);
    chk("R7 hi on after lo off", kHi, 6);

    // R8 timeout with flag stuck at 0
    @(negedge clk);
    swNodeLow = 0;
    settle(5);
    pwmIn = 0;
    measure(1'b0, 1'b1, kHi, kLo);
    chk("R8 hi off in timeout case", kHi, 4);
    chk("R8 lo forced by timeout", kLo, TO_CYC + 5);

    // R8 restart after an aborted falling edge
    @(negedge clk);
    pwmIn = 1;
    settle(20);
    pwmIn = 0;
    settle(3);
    pwmIn = 1;
    settle(20);
    chk("R8 hi back on after aborted fall", int'(hiGate), 1);
    chk("R8 lo stayed off during aborted fall", int'(loGate), 0);
    pwmIn = 0;
    measure(1'b0, 1'b1, kHi, kLo);
    chk("R8 lo after restarted count", kLo, TO_CYC + 5);

    // R5 flag arriving before the timeout
    @(negedge clk);
    pwmIn = 1;
    settle(20);
    pwmIn = 0;
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        swNodeLow = 1;
      end
    join_none
    measure(1'b0, 1'b1, kHi, kLo);
    chk("R5 lo on after late flag", kLo, 7);

    // R1 R9 clamp entry from high-side conduction
    @(negedge clk);
    pwmIn = 1;
    settle(20);
    ovClamp = 1;
    measure(1'b0, 1'b1, kHi, kLo);
    chk("R1 hi off on clamp", kHi, 3);
    chk("R1 lo on on clamp", kLo, 3);

    // R7 R9 clamp exit with pwmIn high
    @(negedge clk);
    ovClamp = 0;
    measure(1'b1, 1'b0, kHi, kLo);
    chk("R9 lo off on clamp exit", kLo, 3);
    chk("R7 hi on after clamp exit", kHi, 5);

    // R3 R9 shutdown and return
    @(negedge clk);
    shutdownN = 0;
    measure(1'b0, 1'b0, kHi, kLo);
    chk("R3 hi off on shutdown", kHi, 3);
    @(negedge clk);
    shutdownN = 1;
    measure(1'b1, 1'b0, kHi, kLo);
    chk("R9 hi on after shutdown exit", kHi, 5);

    // R6 low-side disable with pwmIn low and flag present
    @(negedge clk);
    lowSideEn = 0;
    pwmIn = 0;
    settle(TO_CYC + 15);
    chk("R6 lo held off", int'(loGate), 0);
    chk("R6 hi follows pwm", int'(hiGate), 0);

    chk("R7 overlap count", overlapErr, 0);
    chk("R7 turn-on order violations", orderErr, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule